// File: doc/BRIEF.md
# Register Bit Field Operation Unit

This unit applies one bit-field operation to a 32-bit data word. A field is described by a starting offset and a length. It may begin at any bit position, with no byte alignment. The supported operations are:

- extraction with sign fill or zero fill;
- forcing the field to ones or to zeros;
- inverting the field;
- testing the field without changing it;
- locating the first set bit inside the field.

Each operation also produces negative and zero condition flags.

A caller presents an operation code, a source word, an offset and a width with a valid strobe. One clock later, the unit delivers the result word and flags with a single-cycle result-valid pulse. Offsets count from the most significant bit, and fields that run past the last bit wrap around to the first. A width code of zero stands for a full-word field. The outputs hold their last values until the next strobe.

Top module: `bitfield_unit`

## Requirements
- R1: Operation code 0 (signed extract) returns the field right-justified, with every bit above it equal to the field's first bit.
- R2: Operation code 1 (unsigned extract) returns the field right-justified, with zeros in every bit above it.
- R3: Operation codes 2, 3 and 4 return the source word with every field bit forced to one (2), forced to zero (3) or inverted (4), and every bit outside the field unchanged.
- R4: For every operation, the negative flag equals the field's first bit and the zero flag is set when all field bits are zero. Both flags are taken from the source word, before any change.
- R5: Operation code 5 (test) returns the source word unchanged. The unused code 7 behaves exactly like code 5.
- R6: Operation code 6 (find first one) scans the field from its first bit toward higher offsets. It returns the offset of the first set bit, computed as field offset plus position within the field, with no wrap.
- R7: When the field holds no set bit, operation code 6 returns the field offset plus the field width.
- R8: Offset 0 selects word bit 31, and offset k selects word bit 31-k. A field extends over offsets offset to offset+width-1, and any offset beyond 31 wraps around, so offset 32 selects word bit 31 again.
- R9: The 5-bit width code 0 means a width of 32; any other code is the width itself.
- R10: The result and flags appear one clock after a strobe, with result-valid high for exactly that one cycle. Without a strobe, the outputs hold their values. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_word | input | 32 | Source data word |
| in_off | input | 5 | Field offset, counted from the most significant bit |
| in_wid | input | 5 | Field width code (0 = 32) |
| out_vld | output | 1 | Result valid, one cycle |
| out_word | output | 32 | Result word |
| out_neg | output | 1 | Negative flag |
| out_zero | output | 1 | Zero flag |

## Verification
The bench uses fields that wrap past bit 31 back to bit 0. A design that masks without rotation would touch the wrong bits, and it would report a first-one offset that is off by the word size. The bench also uses full-width fields given by code 0; a design that reads that code as width zero would return empty extracts and a zero flag that is always set.

For set, clear and invert, the bench checks the flags against the field before the change. A design that flags the modified value would report zero after a clear. For an empty field, find first one must return offset plus width; a design returning a found-index of zero or 32 would miss this. Sign fill is checked for fields whose first bit is one and for fields whose first bit is zero.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [2:0] {
      BF_EXTS = 3'd0,
      BF_EXTU = 3'd1,
      BF_SET  = 3'd2,
      BF_CLR  = 3'd3,
      BF_CHG  = 3'd4,
      BF_TST  = 3'd5,
      BF_FFO  = 3'd6,
      BF_RSV  = 3'd7
   } bf_op_e;
endpackage

// File: rtl/bfu_field_align.sv
// Rotates the word so the field's first bit sits at the MSB, and builds
// the field masks in both the rotated and the original bit order.
module bfu_field_align #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word,
   input  logic [POS_W-1:0]  off,
   input  logic [POS_W-1:0]  wid_code,
   output logic [POS_W:0]    len,
   output logic [DATA_W-1:0] rot,
   output logic [DATA_W-1:0] top_mask,
   output logic [DATA_W-1:0] word_mask
);
   localparam logic [POS_W:0] FULL_LEN = (POS_W+1)'(DATA_W);

   logic [2*DATA_W-1:0] rot_dbl;
   logic [2*DATA_W-1:0] msk_dbl;

   // R9: zero code stands for a full-word field
   assign len = (wid_code == '0) ? FULL_LEN : {1'b0, wid_code};

   // R8: rotate left by the offset; wrap comes for free from the doubling
   assign rot_dbl  = {word, word} << off;
   assign rot      = rot_dbl[2*DATA_W-1:DATA_W];

   assign top_mask = ~({DATA_W{1'b1}} >> len);

   // undo the rotation to place the mask over the original word
   assign msk_dbl   = {top_mask, top_mask} >> off;
   assign word_mask = msk_dbl[DATA_W-1:0];
endmodule

// File: rtl/bfu_first_one.sv
// Counts leading zeros of the masked, rotated field.
module bfu_first_one #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] vec,
   output logic              found,
   output logic [POS_W-1:0]  lead
);
   always_comb begin
      found = 1'b0;
      lead  = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (vec[i]) begin
            found = 1'b1;
            lead  = POS_W'(DATA_W - 1 - i);
         end
      end
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bfu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_word,
   input  logic [POS_W-1:0]  in_off,
   input  logic [POS_W-1:0]  in_wid,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_word,
   output logic              out_neg,
   output logic              out_zero
);
   localparam logic [POS_W:0] FULL_LEN = (POS_W+1)'(DATA_W);

   initial begin
      data_w_pow2_chk: assert (DATA_W >= 8 && (DATA_W & (DATA_W - 1)) == 0)
         else $fatal(1, "DATA_W must be a power of two, at least 8");
   end

   bf_op_e              op;
   logic [POS_W:0]      len;
   logic [DATA_W-1:0]   rot, top_mask, word_mask, field_hi;
   logic [DATA_W-1:0]   ext_u, ext_s, low_mask, res_d;
   logic [POS_W:0]      rshift;
   logic                ffo_found;
   logic [POS_W-1:0]    ffo_lead;
   logic [POS_W+1:0]    ffo_pos;
   logic                neg_d, zero_d;

   assign op = bf_op_e'(in_op);

   bfu_field_align #(.DATA_W(DATA_W)) u_align (
      .word      (in_word),
      .off       (in_off),
      .wid_code  (in_wid),
      .len       (len),
      .rot       (rot),
      .top_mask  (top_mask),
      .word_mask (word_mask)
   );

   assign field_hi = rot & top_mask;

   bfu_first_one #(.DATA_W(DATA_W)) u_ffo (
      .vec   (field_hi),
      .found (ffo_found),
      .lead  (ffo_lead)
   );

   // extraction: shift the left-justified field down to bit 0
   assign rshift   = FULL_LEN - len;
   assign ext_u    = field_hi >> rshift;
   assign low_mask = ~({DATA_W{1'b1}} << len);
   assign ext_s    = ext_u | (rot[DATA_W-1] ? ~low_mask : '0);

   // R6 R7: absolute position, no wrap
   assign ffo_pos = ffo_found ? ({2'b00, in_off} + {2'b00, ffo_lead})
                              : ({2'b00, in_off} + {1'b0, len});

   // R4: flags come from the field before modification
   assign neg_d  = rot[DATA_W-1];
   assign zero_d = (field_hi == '0);

   always_comb begin
      unique case (op)
         BF_EXTS: res_d = ext_s;
         BF_EXTU: res_d = ext_u;
         BF_SET:  res_d = in_word | word_mask;
         BF_CLR:  res_d = in_word & ~word_mask;
         BF_CHG:  res_d = in_word ^ word_mask;
         BF_FFO:  res_d = DATA_W'(ffo_pos);
         default: res_d = in_word;
      endcase
   end

   // R10: registered outputs, valid pulse follows the strobe
   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_word <= '0;
         out_neg  <= 1'b0;
         out_zero <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_word <= res_d;
            out_neg  <= neg_d;
            out_zero <= zero_d;
         end
      end
   end

   // R10
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);
   // R10
   vld_single_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> (!out_vld && $stable(out_word)));
   // R3
   outside_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (op == BF_SET || op == BF_CLR || op == BF_CHG)) |=>
      (((out_word ^ $past(in_word)) & ~$past(word_mask)) == '0));
   // R5
   test_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (op == BF_TST || op == BF_RSV)) |=> (out_word == $past(in_word)));
   // R7
   ffo_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && op == BF_FFO) |=>
      (out_word <= DATA_W'({2'b00, $past(in_off)} + {1'b0, $past(len)})));
   // R2 R4
   extu_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && op == BF_EXTU) |=> (out_zero == (out_word == '0)));
endmodule

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [2:0]  in_op;
   logic [31:0] in_word;
   logic [4:0]  in_off, in_wid;
   logic        out_vld, out_neg, out_zero;
   logic [31:0] out_word;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   bitfield_unit u_bitfield_unit (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
      .in_word(in_word), .in_off(in_off), .in_wid(in_wid),
      .out_vld(out_vld), .out_word(out_word),
      .out_neg(out_neg), .out_zero(out_zero)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Reference model, bit by bit from the requirements
   task automatic model(input int op, input logic [31:0] w, input int o,
                        input int wc, output logic [31:0] r,
                        output logic n, output logic z);
      int len = (wc == 0) ? 32 : wc;
      longint f = 0;
      int first = -1;
      r = w;
      for (int k = 0; k < len; k++) begin
         int idx = 31 - ((o + k) % 32);
         f = (f << 1) | longint'(w[idx]);
         if (w[idx] && first < 0) first = k;
         case (op)
            2: r[idx] = 1'b1;
            3: r[idx] = 1'b0;
            4: r[idx] = ~w[idx];
            default: ;
         endcase
      end
      n = w[31 - o];
      z = (f == 0);
      case (op)
         0: begin
            if (n) f = f | ~((64'd1 << len) - 1);
            r = f[31:0];
         end
         1: r = f[31:0];
         6: r = (first < 0) ? 32'(o + len) : 32'(o + first);
         default: ;
      endcase
   endtask

   task automatic run(string req, int op, logic [31:0] w, int o, int wc);
      logic [31:0] er; logic en, ez;
      model(op, w, o, wc, er, en, ez);
      @(negedge clk);
      in_op = 3'(op); in_word = w; in_off = 5'(o); in_wid = 5'(wc); in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      check({req, " R10 valid"}, {31'd0, out_vld}, 32'd1);
      check({req, " word"}, out_word, er);
      check({req, " R4 neg"}, {31'd0, out_neg}, {31'd0, en});
      check({req, " R4 zero"}, {31'd0, out_zero}, {31'd0, ez});
   endtask

   task automatic t_reset();
      check("R10 reset valid", {31'd0, out_vld}, 32'd0);
      check("R10 reset word", out_word, 32'd0);
      check("R10 reset flags", {30'd0, out_neg, out_zero}, 32'd0);
   endtask

   task automatic t_extract();
      run("R1 exts neg", 0, 32'h0000_00F0, 24, 8);
      check("R1 exts literal", out_word, 32'hFFFF_FFF0);
      run("R2 extu", 1, 32'h0000_00F0, 24, 8);
      check("R2 extu literal", out_word, 32'h0000_00F0);
      run("R1 exts pos", 0, 32'h1234_5678, 4, 12);
      check("R1 R8 exts literal", out_word, 32'h0000_0234);
      run("R8 wrap extu", 1, 32'hA000_0005, 28, 8);
      check("R8 wrap literal", out_word, 32'h0000_005A);
      run("R9 full exts", 0, 32'h8000_0001, 0, 0);
      check("R9 full literal", out_word, 32'h8000_0001);
      run("R9 rot full extu", 1, 32'h1234_5678, 8, 0);
      check("R9 R8 rotate literal", out_word, 32'h3456_7812);
   endtask

   task automatic t_modify();
      run("R3 set", 2, 32'h0000_0000, 8, 4);
      check("R3 set literal", out_word, 32'h00F0_0000);
      run("R3 clr", 3, 32'hFFFF_FFFF, 30, 4);
      check("R3 clr wrap literal", out_word, 32'h3FFF_FFFC);
      check("R4 clr prior zero", {31'd0, out_zero}, 32'd0);
      run("R3 chg", 4, 32'h0F0F_0F0F, 2, 10);
      run("R4 set prior zero", 2, 32'h0000_0000, 0, 0);
      check("R4 set flag literal", {31'd0, out_zero}, 32'd1);
   endtask

   task automatic t_test();
      run("R5 tst", 5, 32'hDEAD_BEEF, 3, 7);
      check("R5 tst literal", out_word, 32'hDEAD_BEEF);
      run("R5 code7", 7, 32'h0000_0001, 31, 1);
      check("R5 code7 literal", out_word, 32'h0000_0001);
   endtask

   task automatic t_ffo();
      run("R6 ffo", 6, 32'h0010_0000, 4, 16);
      check("R6 ffo literal", out_word, 32'd11);
      run("R6 ffo wrap", 6, 32'h4000_0000, 30, 8);
      check("R6 wrap literal", out_word, 32'd33);
      run("R7 ffo none", 6, 32'hFF00_00FF, 10, 12);
      check("R7 none literal", out_word, 32'd22);
      run("R7 R9 ffo empty full", 6, 32'h0000_0000, 31, 0);
      check("R7 R9 literal", out_word, 32'd63);
   endtask

   task automatic t_hold();
      logic [31:0] prev;
      run("R10 base", 1, 32'hCAFE_F00D, 16, 16);
      prev = out_word;
      in_word = 32'h1111_1111; in_op = 3'd3;
      @(negedge clk);
      check("R10 valid drop", {31'd0, out_vld}, 32'd0);
      @(negedge clk);
      check("R10 hold word", out_word, prev);
   endtask

   initial begin
      rst = 1'b1; in_vld = 1'b0; in_op = '0; in_word = '0; in_off = '0; in_wid = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_extract();
      t_modify();
      t_test();
      t_ffo();
      t_hold();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule